// File: doc/BRIEF.md
# Instruction-Cycle Clock Source Switcher

This block chooses which of two oscillators paces the processor core: a slow secondary oscillator or the main oscillator. Both arrive as raw square waves and are sampled by a fast system clock, `clk`. A rising edge of the chosen oscillator advances a four-phase ring, and the ring drives the one-hot phase strobes Q1..Q4. The block also drives enables for both oscillators, so that an oscillator runs only while the block needs it.

A select input asks for the main oscillator. Before the main oscillator is allowed to drive the core, it must warm up. In the RC and external-clock mode codes the warm-up is a short count of main edges. In the crystal mode codes it is a long start-up count. The changeover is made only at the end of Q4, so the core never sees a truncated phase. A sleep request lets the current instruction cycle run to its end, then parks the ring at Q1 and stops both oscillators. An external reset event, a watchdog reset event or an interrupt wakes the block. If the main oscillator was in use, it warms up again before the phases resume.

States and transitions:
- RUN to DRAIN on a sleep request. Otherwise RUN to WARMUP when main is selected but not in use, or RUN to ALIGN when the secondary is selected but not in use.
- WARMUP to RUN (abort) when the select drops, or WARMUP to ALIGN when the warm-up count completes.
- ALIGN to RUN at the Q4-to-Q1 step. The source flips at that step.
- DRAIN to PARKED at the Q4-to-Q1 step.
- PARKED to RESTART on a wake event while on main, or PARKED to RUN on a wake event while on the secondary.
- RESTART to RUN when the warm-up count completes.

Top module: `qclk_switch`

## Requirements
- R1: After reset, `q` is 4'b0001 (Q1), `switching` is 0, `main_en` is 0, `sec_en` is 1, and the secondary oscillator is the source.
- R2: `q` is one-hot at all times, with bit 0 = Q1 through bit 3 = Q4. It rotates Q1→Q2→Q3→Q4→Q1, one step per rising edge of the source oscillator.
- R3: For `osc_mode` codes 3, 4, 5 and 6 (RC and external-clock modes), a switch to main waits for 8 rising edges of the main oscillator after `main_en` rises.
- R4: For `osc_mode` codes 0, 1, 2 (crystal modes) and 7, the wait is 1024 main-oscillator rising edges.
- R5: The source changes only at a Q4-to-Q1 step. Until then the old oscillator keeps advancing `q`, including during warm-up.
- R6: A switch back to the secondary oscillator needs no warm-up. It completes at the next Q4-to-Q1 step of the main oscillator, and `main_en` falls at that same point.
- R7: If `sel_main` drops during warm-up, the switch is abandoned. One cycle later, `switching` and `main_en` are both 0.
- R8: A one-cycle `sleep_req` lets phases run to the end of Q4. After that, `q` stays at Q1, and `main_en` and `sec_en` are both 0.
- R9: Any one of `wk_ext`, `wk_wdt` or `wk_irq` ends sleep. On the secondary oscillator, phases resume at once. On the main oscillator, `q` holds Q1 with `switching` at 0 while the R3/R4 warm-up count repeats, then phases resume.
- R10: `switching` is high from the cycle after the select change until the new source takes over at Q1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_osc | input | 1 | Raw main oscillator waveform |
| sec_osc | input | 1 | Raw secondary oscillator waveform |
| sel_main | input | 1 | 1 selects the main oscillator, 0 selects the secondary |
| osc_mode | input | 3 | Main oscillator mode code (0-2 and 7 crystal; 3-6 RC/external) |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| wk_ext | input | 1 | External reset wake event |
| wk_wdt | input | 1 | Watchdog reset wake event |
| wk_irq | input | 1 | Interrupt wake event |
| q | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| switching | output | 1 | Source change under way |
| main_en | output | 1 | Run request for the main oscillator |
| sec_en | output | 1 | Run request for the secondary oscillator |

## Verification
The assertions rely on three properties of the inputs:
- Each oscillator is much slower than `clk`, so every high and every low level is seen by the synchronizer.
- An oscillator stays low while its enable is low.
- `sleep_req` and the wake events are single-cycle pulses, and `osc_mode` is steady while a warm-up is counting.

The bench's oscillator models follow these rules by construction. Each model toggles only while its enable is high, and drops to low and restarts when its enable falls. The secondary half-period is 2 `clk` cycles and the main half-period is 20. The bench changes `osc_mode` only while the block is in RUN on the secondary, and it drives every request and wake event for exactly one cycle.

// File: rtl/qclk_pkg.sv
package qclk_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WARMUP,
        ST_ALIGN,
        ST_DRAIN,
        ST_PARKED,
        ST_RESTART
    } qclk_state_t;

    // Mode codes 3..6 are RC / external-clock modes needing only a short count
    function automatic logic mode_is_fast(input logic [2:0] code);
        return (code >= 3'd3) && (code <= 3'd6);
    endfunction

endpackage

// File: rtl/qclk_edge_tick.sv
module qclk_edge_tick #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic tick
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[MSB-1:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[MSB];
    end

    assign tick = sync_q[MSB] & ~prev_q;

    // R2: a rising edge produces one single-cycle pulse
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/qclk_phase_ring.sv
module qclk_phase_ring #(
    parameter int NPHASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [NPHASE-1:0] q
);
    localparam logic [NPHASE-1:0] FIRST = NPHASE'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= FIRST;
        else if (adv) q <= {q[NPHASE-2:0], q[NPHASE-1]};
    end

    a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(q));

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));

endmodule

// File: rtl/qclk_settle_count.sv
module qclk_settle_count #(
    parameter int SHORT_WAIT = 8,
    parameter int LONG_WAIT  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic long_sel,
    output logic done
);
    localparam int CW = $clog2(LONG_WAIT);

    logic [CW-1:0] cnt;
    logic [CW:0]   lim;

    assign lim  = long_sel ? (CW+1)'(LONG_WAIT) : (CW+1)'(SHORT_WAIT);
    assign done = run & tick & ({1'b0, cnt} == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // R3/R4: the count never passes its limit while it runs
    a_r3_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, cnt} < lim));

endmodule

// File: rtl/qclk_switch.sv
module qclk_switch
    import qclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_WAIT  = 8,
    parameter int LONG_WAIT   = 1024,
    parameter int NPHASE      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_osc,
    input  logic              sec_osc,
    input  logic              sel_main,
    input  logic [2:0]        osc_mode,
    input  logic              sleep_req,
    input  logic              wk_ext,
    input  logic              wk_wdt,
    input  logic              wk_irq,
    output logic [NPHASE-1:0] q,
    output logic              switching,
    output logic              main_en,
    output logic              sec_en
);
    localparam logic [NPHASE-1:0] PH_FIRST = NPHASE'(1);
    localparam logic [NPHASE-1:0] PH_LAST  = PH_FIRST << (NPHASE - 1);

    qclk_state_t st, st_nx;
    logic        cur_main;
    logic        mtick_raw, mtick, stick;
    logic        adv, boundary;
    logic        wait_run, wait_done;
    logic        wake;

    qclk_edge_tick #(.STAGES(SYNC_STAGES)) u_main_edge (
        .clk(clk), .rst_n(rst_n), .raw(main_osc), .tick(mtick_raw));
    qclk_edge_tick #(.STAGES(SYNC_STAGES)) u_sec_edge (
        .clk(clk), .rst_n(rst_n), .raw(sec_osc), .tick(stick));

    assign mtick    = mtick_raw & main_en;
    assign boundary = adv & q[NPHASE-1];
    assign wake     = wk_ext | wk_wdt | wk_irq;

    qclk_settle_count #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .tick(mtick),
        .long_sel(!mode_is_fast(osc_mode)), .done(wait_done));

    qclk_phase_ring #(.NPHASE(NPHASE)) u_ring (
        .clk(clk), .rst_n(rst_n), .adv(adv), .q(q));

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN: begin
                if (sleep_req)                  st_nx = ST_DRAIN;
                else if (sel_main != cur_main)  st_nx = sel_main ? ST_WARMUP : ST_ALIGN;
            end
            ST_WARMUP: begin
                if (!sel_main)                  st_nx = ST_RUN;
                else if (wait_done)             st_nx = ST_ALIGN;
            end
            ST_ALIGN:   if (boundary)  st_nx = ST_RUN;
            ST_DRAIN:   if (boundary)  st_nx = ST_PARKED;
            ST_PARKED:  if (wake)      st_nx = cur_main ? ST_RESTART : ST_RUN;
            ST_RESTART: if (wait_done) st_nx = ST_RUN;
            default:                   st_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_RUN;
            cur_main <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_ALIGN && boundary) cur_main <= ~cur_main;
        end
    end

    // outputs
    always_comb begin
        switching = 1'b0;
        main_en   = cur_main;
        sec_en    = 1'b1;
        adv       = cur_main ? mtick_raw : stick;
        wait_run  = 1'b0;
        unique case (st)
            ST_WARMUP: begin
                switching = 1'b1;
                main_en   = 1'b1;
                wait_run  = 1'b1;
            end
            ST_ALIGN: begin
                switching = 1'b1;
                main_en   = 1'b1;
            end
            ST_PARKED: begin
                main_en = 1'b0;
                sec_en  = 1'b0;
                adv     = 1'b0;
            end
            ST_RESTART: begin
                main_en  = 1'b1;
                sec_en   = 1'b0;
                adv      = 1'b0;
                wait_run = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: the source flips only as Q4 steps to Q1
    a_r5_flip_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_main) |-> (q == PH_FIRST && $past(q) == PH_LAST));

    // R8: parked means Q1 and both oscillators off
    a_r8_parked_q1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PARKED) |-> (q == PH_FIRST && !main_en && !sec_en));

    // R9: phases stay frozen at Q1 while the main oscillator restarts
    a_r9_restart_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESTART) |-> (q == PH_FIRST && !switching));

    // R7: dropping the select during warm-up abandons the switch
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WARMUP && !sel_main) |=> (!switching && !main_en));

    // R10: a completed switch ends at Q1
    a_r10_flag_ends_q1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(switching) && $past(st) == ST_ALIGN) |-> (q == PH_FIRST));

endmodule

// File: tb/sim_qclk_switch.sv
`timescale 1ns/1ps
module sim_qclk_switch;

    localparam int MHALF = 20;
    localparam int SHALF = 2;
    localparam int NVEC  = 5;
    localparam int VMODE [NVEC] = '{3, 4, 5, 6, 0};
    localparam int VWAIT [NVEC] = '{8, 8, 8, 8, 1024};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       main_osc = 1'b0, sec_osc = 1'b0;
    logic       sel_main = 1'b0, sleep_req = 1'b0;
    logic       wk_ext = 1'b0, wk_wdt = 1'b0, wk_irq = 1'b0;
    logic [2:0] osc_mode = 3'd3;
    logic [3:0] q;
    logic       switching, main_en, sec_en;

    int unsigned mrise = 0;
    int          mcnt = 0, scnt = 0;
    int          n_chk = 0, n_bad = 0;

    qclk_switch u0 (
        .clk(clk), .rst_n(rst_n), .main_osc(main_osc), .sec_osc(sec_osc),
        .sel_main(sel_main), .osc_mode(osc_mode), .sleep_req(sleep_req),
        .wk_ext(wk_ext), .wk_wdt(wk_wdt), .wk_irq(wk_irq),
        .q(q), .switching(switching), .main_en(main_en), .sec_en(sec_en));

    // oscillator models: run only while enabled
    always @(negedge clk) begin
        if (!main_en) begin
            main_osc <= 1'b0; mcnt <= 0;
        end else if (mcnt == MHALF - 1) begin
            mcnt <= 0; main_osc <= ~main_osc;
            if (!main_osc) mrise <= mrise + 1;
        end else mcnt <= mcnt + 1;
    end

    always @(negedge clk) begin
        if (!sec_en) begin
            sec_osc <= 1'b0; scnt <= 0;
        end else if (scnt == SHALF - 1) begin
            scnt <= 0; sec_osc <= ~sec_osc;
        end else scnt <= scnt + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_mrise(input int unsigned tgt);
        while (mrise < tgt) @(posedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    // counts phase steps over n cycles and flags any step that is not a rotation
    task automatic watch_phases(input int n, output int steps, output int bad_steps);
        logic [3:0] prev;
        prev = q; steps = 0; bad_steps = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (q != prev) begin
                if (q != {prev[2:0], prev[3]}) bad_steps++;
                steps++;
                prev = q;
            end
        end
    endtask

    task automatic go_main(input int mode, input int nwait, input string req);
        int unsigned base;
        int st, bs;
        osc_mode = 3'(mode);
        base = mrise;
        @(negedge clk) sel_main = 1'b1;
        @(negedge clk);
        check(switching == 1'b1, "R10", switching, 1);
        watch_phases(12, st, bs);
        check(st > 0 && bs == 0, "R5", st, 1);
        wait_mrise(base + nwait - 1);
        repeat (34) @(negedge clk);
        check(switching == 1'b1, req, switching, 1);
        wait_mrise(base + nwait);
        repeat (34) @(negedge clk);
        check(switching == 1'b0 && q == 4'b0001, req, {switching, q}, 1);
    endtask

    task automatic go_sec();
        int k;
        @(negedge clk) sel_main = 1'b0;
        @(negedge clk);
        check(switching == 1'b1, "R10", switching, 1);
        k = 0;
        while (switching && k < 400) begin @(negedge clk); k++; end
        check(q == 4'b0001 && main_en == 1'b0, "R6", {main_en, q}, 1);
    endtask

    initial begin : watchdog
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main_seq
        int st, bs;
        int unsigned base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(q == 4'b0001 && !switching && !main_en && sec_en, "R1",
              {switching, main_en, sec_en, q}, 7'b0010001);

        watch_phases(60, st, bs);
        check(st >= 10 && bs == 0, "R2", st, 15);

        // vector walk: switch to main per mode, then back
        for (int i = 0; i < NVEC; i++) begin
            go_main(VMODE[i], VWAIT[i], (VWAIT[i] == 8) ? "R3" : "R4");
            go_sec();
        end

        // R7: abort during a long warm-up
        osc_mode = 3'd0;
        base = mrise;
        @(negedge clk) sel_main = 1'b1;
        wait_mrise(base + 5);
        repeat (5) @(negedge clk);
        sel_main = 1'b0;
        repeat (2) @(negedge clk);
        check(!switching && !main_en, "R7", {switching, main_en}, 0);

        // R8 / R9: sleep and wake on secondary, one wake source each time
        for (int w = 0; w < 3; w++) begin
            pulse(sleep_req);
            repeat (30) @(negedge clk);
            check(q == 4'b0001 && !sec_en && !main_en, "R8", {sec_en, main_en, q}, 1);
            repeat (20) @(negedge clk);
            check(q == 4'b0001, "R8", q, 1);
            if (w == 0)      pulse(wk_ext);
            else if (w == 1) pulse(wk_wdt);
            else             pulse(wk_irq);
            watch_phases(40, st, bs);
            check(sec_en && st > 0 && bs == 0, "R9", st, 10);
        end

        // R9: wake on main oscillator with short warm-up
        go_main(3, 8, "R3");
        pulse(sleep_req);
        repeat (200) @(negedge clk);
        check(q == 4'b0001 && !main_en, "R8", {main_en, q}, 1);
        pulse(wk_irq);
        base = mrise;
        wait_mrise(base + 8);
        repeat (10) @(negedge clk);
        check(q == 4'b0001 && !switching && main_en, "R9", q, 1);
        wait_mrise(base + 9);
        repeat (10) @(negedge clk);
        check(q == 4'b0010, "R9", q, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule